// File: doc/BRIEF.md
# Variable-Page-Size Translation Buffer

This block is a fully associative address translation buffer with a fixed set of entries. Each entry maps one page, and the page size is chosen per entry from eight sizes between 1 KB and 16 MB. Each entry also carries an 8-bit address-space tag. A request presents a 32-bit effective address, the side it comes from (instruction or data) and the current process tag. Every valid entry whose tag equals the process tag compares the address under its own page mask. The lowest-numbered matching entry supplies the real page. The untouched offset bits of the request are appended to that page.

Each side has its own translation enable. When the enable for the requesting side is off, the address is returned unchanged. When translation is on and nothing matches, the result carries a miss flag for that side, and miss-handling software is expected to refill the buffer. Entries are loaded and inspected through a simple indexed write port and a registered read port. Access rights, zones and storage attributes are not checked here.

Top module: `vtlb_top`

## Requirements
- R1: A synchronous active-high reset clears every entry's valid flag and all registered outputs. After reset, every translated lookup misses.
- R2: The size code in entry high-word bits [9:7] selects the compare mask. Code k keeps address bits [31:10+2k], so code 0 gives a 1 KB page and code 7 gives a 16 MB page.
- R3: An entry takes part in a lookup only when its valid flag (high-word bit 6) is set and its stored tag equals `lk_pid`.
- R4: An entry hits when the request address and the entry high word agree on every bit kept by its mask. The physical address is then the low word under that mask, ORed with the request address bits outside the mask.
- R5: When the enable for the requesting side is off (`lk_side` 0 uses `xlate_i_en`, 1 uses `xlate_d_en`), the result is a hit with `res_paddr` equal to the request address and `res_idx` 0.
- R6: A translated lookup with no hit raises `res_miss_i` when `lk_side` is 0 and `res_miss_d` when it is 1. At most one of `res_hit`, `res_miss_i` and `res_miss_d` is set.
- R7: When several entries hit, the entry with the lowest index supplies the result and `res_idx`.
- R8: A write stores the high word, low word and tag at `wr_idx` at the clock edge. The valid flag takes high-word bit 6. A lookup in the same cycle still sees the old contents. A read returns the entry one cycle after `rd_en`, with bit 6 showing the live valid flag. A read in the same cycle as a write to that entry returns the old contents.
- R9: The result appears one cycle after `lk_valid`, flagged by `res_valid`. In cycles after an idle request, `res_valid`, `res_hit` and both miss flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_hi | input | 32 | High word: page [31:10], size code [9:7], valid [6] |
| wr_lo | input | 32 | Low word: real page |
| wr_tid | input | 8 | Address-space tag of the entry |
| rd_en | input | 1 | Entry read strobe |
| rd_idx | input | 6 | Entry index to read |
| rd_hi | output | 32 | High word read back, bit 6 showing the live valid flag |
| rd_lo | output | 32 | Low word read back |
| rd_tid | output | 8 | Tag read back |
| lk_valid | input | 1 | Lookup request |
| lk_side | input | 1 | 0 = instruction, 1 = data |
| lk_addr | input | 32 | Effective address |
| lk_pid | input | 8 | Current process tag |
| xlate_i_en | input | 1 | Instruction-side translation enable |
| xlate_d_en | input | 1 | Data-side translation enable |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | Translation produced an address |
| res_miss_i | output | 1 | Instruction-side miss |
| res_miss_d | output | 1 | Data-side miss |
| res_paddr | output | 32 | Physical address |
| res_idx | output | 6 | Index of the winning entry |

## Verification
The bench builds one page of each size and probes it just inside and just outside its upper edge. A wrong mask table would hit outside the page or miss inside it, and a wrong offset merge would corrupt the low bits of `res_paddr`. Tag mismatches, cleared valid flags and overlapping entries are used to catch an entry that joins a lookup it should not, or a priority that picks the highest index. Pass-through with one side disabled checks that the enable of the other side is not consulted. Writes and reads that collide with a lookup in the same cycle check that new contents do not leak into that cycle's result.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  localparam int SIZE_W        = 3;
  localparam int SIZE_LSB      = 7;
  localparam int VALID_BIT     = 6;
  localparam int MIN_PAGE_BITS = 10;
  localparam int PAGE_STEP     = 2;

  typedef enum logic {SIDE_INSN = 1'b0, SIDE_DATA = 1'b1} side_e;

  function automatic logic [31:0] page_mask(input logic [SIZE_W-1:0] code);
    page_mask = 32'hFFFF_FFFF << (MIN_PAGE_BITS + PAGE_STEP * int'(code));
  endfunction
endpackage

// File: rtl/vtlb_store.sv
module vtlb_store import vtlb_pkg::*; #(
  parameter int N    = 64,
  parameter int AW   = 32,
  parameter int TW   = 8,
  localparam int IW  = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [AW-1:0]       wr_hi,
  input  logic [AW-1:0]       wr_lo,
  input  logic [TW-1:0]       wr_tid,
  input  logic                rd_en,
  input  logic [IW-1:0]       rd_idx,
  output logic [AW-1:0]       rd_hi,
  output logic [AW-1:0]       rd_lo,
  output logic [TW-1:0]       rd_tid,
  output logic [N-1:0][AW-1:0] ent_hi,
  output logic [N-1:0][AW-1:0] ent_lo,
  output logic [N-1:0][TW-1:0] ent_tid,
  output logic [N-1:0]        ent_vld
);
  always_ff @(posedge clk) begin
    if (rst) ent_vld <= '0;
    else if (wr_en) ent_vld[wr_idx] <= wr_hi[VALID_BIT];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_hi[wr_idx]  <= wr_hi;
      ent_lo[wr_idx]  <= wr_lo;
      ent_tid[wr_idx] <= wr_tid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hi  <= '0;
      rd_lo  <= '0;
      rd_tid <= '0;
    end else if (rd_en) begin
      rd_hi            <= ent_hi[rd_idx];
      rd_hi[VALID_BIT] <= ent_vld[rd_idx];
      rd_lo            <= ent_lo[rd_idx];
      rd_tid           <= ent_tid[rd_idx];
    end
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) $past(rst) |-> ent_vld == '0); // R1
  AST_WRITE_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ent_vld[$past(wr_idx)] == $past(wr_hi[VALID_BIT])); // R8
endmodule

// File: rtl/vtlb_match.sv
module vtlb_match import vtlb_pkg::*; #(
  parameter int N  = 64,
  parameter int AW = 32,
  parameter int TW = 8
) (
  input  logic [N-1:0][AW-1:0] ent_hi,
  input  logic [N-1:0][TW-1:0] ent_tid,
  input  logic [N-1:0]         ent_vld,
  input  logic [AW-1:0]        addr,
  input  logic [TW-1:0]        pid,
  output logic [N-1:0]         hit_vec
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic [AW-1:0] msk;
    assign msk        = page_mask(ent_hi[g][SIZE_LSB +: SIZE_W]);
    assign hit_vec[g] = ent_vld[g] && (ent_tid[g] == pid) &&
                        (((addr ^ ent_hi[g]) & msk) == '0);
  end
endmodule

// File: rtl/vtlb_prio.sv
module vtlb_prio #(
  parameter int N   = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/vtlb_top.sv
module vtlb_top import vtlb_pkg::*; #(
  parameter int N    = 64,
  parameter int AW   = 32,
  parameter int TW   = 8,
  localparam int IW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_hi,
  input  logic [AW-1:0] wr_lo,
  input  logic [TW-1:0] wr_tid,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_hi,
  output logic [AW-1:0] rd_lo,
  output logic [TW-1:0] rd_tid,
  input  logic          lk_valid,
  input  logic          lk_side,
  input  logic [AW-1:0] lk_addr,
  input  logic [TW-1:0] lk_pid,
  input  logic          xlate_i_en,
  input  logic          xlate_d_en,
  output logic          res_valid,
  output logic          res_hit,
  output logic          res_miss_i,
  output logic          res_miss_d,
  output logic [AW-1:0] res_paddr,
  output logic [IW-1:0] res_idx
);
  logic [N-1:0][AW-1:0] ent_hi, ent_lo;
  logic [N-1:0][TW-1:0] ent_tid;
  logic [N-1:0]         ent_vld, hit_vec;
  logic                 any_hit, xlate_on;
  logic [IW-1:0]        win;
  logic [AW-1:0]        win_mask, paddr_sel;

  vtlb_store #(.N(N), .AW(AW), .TW(TW)) u_store (
    .clk, .rst, .wr_en, .wr_idx, .wr_hi, .wr_lo, .wr_tid,
    .rd_en, .rd_idx, .rd_hi, .rd_lo, .rd_tid,
    .ent_hi, .ent_lo, .ent_tid, .ent_vld
  );

  vtlb_match #(.N(N), .AW(AW), .TW(TW)) u_match (
    .ent_hi, .ent_tid, .ent_vld, .addr(lk_addr), .pid(lk_pid), .hit_vec
  );

  vtlb_prio #(.N(N)) u_prio (.req(hit_vec), .any(any_hit), .idx(win));

  assign xlate_on  = (lk_side == SIDE_DATA) ? xlate_d_en : xlate_i_en;
  assign win_mask  = page_mask(ent_hi[win][SIZE_LSB +: SIZE_W]);
  assign paddr_sel = (ent_lo[win] & win_mask) | (lk_addr & ~win_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_miss_i <= 1'b0;
      res_miss_d <= 1'b0;
      res_paddr  <= '0;
      res_idx    <= '0;
    end else begin
      res_valid  <= lk_valid;
      res_hit    <= 1'b0;
      res_miss_i <= 1'b0;
      res_miss_d <= 1'b0;
      res_paddr  <= '0;
      res_idx    <= '0;
      if (lk_valid) begin
        if (!xlate_on) begin
          res_hit   <= 1'b1;
          res_paddr <= lk_addr;
        end else if (any_hit) begin
          res_hit   <= 1'b1;
          res_paddr <= paddr_sel;
          res_idx   <= win;
        end else if (lk_side == SIDE_DATA) begin
          res_miss_d <= 1'b1;
        end else begin
          res_miss_i <= 1'b1;
        end
      end
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid && !res_hit && !res_miss_i && !res_miss_d); // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({res_hit, res_miss_i, res_miss_d})); // R6
  AST_MISS_SIDE_D: assert property (@(posedge clk) disable iff (rst)
    lk_valid && xlate_on && !any_hit && lk_side |=> res_miss_d); // R6
  AST_MISS_SIDE_I: assert property (@(posedge clk) disable iff (rst)
    lk_valid && xlate_on && !any_hit && !lk_side |=> res_miss_i); // R6
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    lk_valid && !xlate_on |=> res_hit && res_paddr == $past(lk_addr)); // R5
  AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    lk_valid && xlate_on && any_hit |=> res_hit && (res_idx == $past(win))); // R7
endmodule

// File: tb/vtlb_top_test.sv
module vtlb_top_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en, lk_valid, lk_side, xlate_i_en, xlate_d_en;
  logic [5:0]  wr_idx, rd_idx;
  logic [31:0] wr_hi, wr_lo, lk_addr;
  logic [7:0]  wr_tid, lk_pid;
  logic [31:0] rd_hi, rd_lo, res_paddr;
  logic [7:0]  rd_tid;
  logic        res_valid, res_hit, res_miss_i, res_miss_d;
  logic [5:0]  res_idx;

  always #2 clk = ~clk;

  vtlb_top uut (
    .clk, .rst, .wr_en, .wr_idx, .wr_hi, .wr_lo, .wr_tid,
    .rd_en, .rd_idx, .rd_hi, .rd_lo, .rd_tid,
    .lk_valid, .lk_side, .lk_addr, .lk_pid, .xlate_i_en, .xlate_d_en,
    .res_valid, .res_hit, .res_miss_i, .res_miss_d, .res_paddr, .res_idx
  );

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit done = 0;

  logic [31:0] m_hi [64];
  logic [31:0] m_lo [64];
  logic [7:0]  m_tid [64];
  bit          m_vld [64];
  logic [31:0] e_rd_hi = 0, e_rd_lo = 0;
  logic [7:0]  e_rd_tid = 0;

  function automatic logic [31:0] mask_of(input logic [2:0] s);
    return ~((32'd1 << (10 + 2 * int'(s))) - 32'd1);
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic tick();
    logic ev = 0, eh = 0, emi = 0, emd = 0;
    logic [31:0] ep = 0, m;
    logic [5:0] ei = 0;
    int found = -1;
    if (rst) begin
      for (int i = 0; i < 64; i++) m_vld[i] = 0;
      e_rd_hi = 0; e_rd_lo = 0; e_rd_tid = 0;
    end else begin
      ev = lk_valid;
      if (lk_valid) begin
        if (!(lk_side ? xlate_d_en : xlate_i_en)) begin
          eh = 1; ep = lk_addr;
        end else begin
          for (int i = 0; i < 64; i++)
            if (found < 0 && m_vld[i] && m_tid[i] == lk_pid &&
                ((lk_addr ^ m_hi[i]) & mask_of(m_hi[i][9:7])) == 0) found = i;
          if (found >= 0) begin
            m = mask_of(m_hi[found][9:7]);
            eh = 1; ei = 6'(found);
            ep = (m_lo[found] & m) | (lk_addr & ~m);
          end else if (lk_side) emd = 1;
          else emi = 1;
        end
      end
      if (rd_en) begin
        e_rd_hi = m_hi[rd_idx]; e_rd_hi[6] = m_vld[rd_idx];
        e_rd_lo = m_lo[rd_idx]; e_rd_tid = m_tid[rd_idx];
      end
      if (wr_en) begin
        m_hi[wr_idx] = wr_hi; m_lo[wr_idx] = wr_lo;
        m_tid[wr_idx] = wr_tid; m_vld[wr_idx] = wr_hi[6];
      end
    end
    @(posedge clk); #1;
    chk("res_valid", 32'(res_valid), 32'(ev));
    chk("res_hit", 32'(res_hit), 32'(eh));
    chk("res_miss_i", 32'(res_miss_i), 32'(emi));
    chk("res_miss_d", 32'(res_miss_d), 32'(emd));
    chk("res_paddr", res_paddr, ep);
    chk("res_idx", 32'(res_idx), 32'(ei));
    chk("rd_hi", rd_hi, e_rd_hi);
    chk("rd_lo", rd_lo, e_rd_lo);
    chk("rd_tid", 32'(rd_tid), 32'(e_rd_tid));
  endtask

  task automatic idle_inputs();
    wr_en = 0; rd_en = 0; lk_valid = 0;
  endtask

  task automatic write_ent(input int i, input logic [31:0] hi, input logic [31:0] lo,
                           input logic [7:0] tid);
    wr_en = 1; wr_idx = 6'(i); wr_hi = hi; wr_lo = lo; wr_tid = tid;
    tick(); idle_inputs();
  endtask

  task automatic look(input logic side, input logic [31:0] a, input logic [7:0] pid);
    lk_valid = 1; lk_side = side; lk_addr = a; lk_pid = pid;
    tick(); idle_inputs();
  endtask

  task automatic read_ent(input int i);
    rd_en = 1; rd_idx = 6'(i);
    tick(); idle_inputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    rst = 1; idle_inputs();
    wr_idx = 0; wr_hi = 0; wr_lo = 0; wr_tid = 0; rd_idx = 0;
    lk_side = 0; lk_addr = 0; lk_pid = 0; xlate_i_en = 1; xlate_d_en = 1;
    #1;
    cur_req = "R1"; tick(); tick();
    rst = 0;
    look(1'b1, 32'h0000_1234, 8'h00);
    look(1'b0, 32'h0800_0000, 8'h11);

    cur_req = "R2";
    for (int s = 0; s < 8; s++) begin
      base = 32'h0100_0000 * (s + 1);
      write_ent(8 + s, base | (32'(s) << 7) | 32'h40, {8'h80 + 8'(s), 24'hABCDEF}, 8'h11);
    end
    for (int s = 0; s < 8; s++) begin
      base = 32'h0100_0000 * (s + 1);
      cur_req = "R2"; look(1'b1, base + (32'd1 << (10 + 2 * s)) - 32'd4, 8'h11);
      cur_req = "R4"; look(1'b1, base + 32'h155, 8'h11);
      cur_req = "R2"; look(1'b1, base + (32'd1 << (10 + 2 * s)), 8'h11);
    end

    cur_req = "R3";
    look(1'b1, 32'h0400_0010, 8'h12);
    look(1'b0, 32'h0400_0010, 8'h12);
    write_ent(11, 32'h0400_0000 | (32'd3 << 7), 32'h9000_0000, 8'h11);
    look(1'b1, 32'h0400_0010, 8'h11);

    cur_req = "R7";
    write_ent(20, 32'h2000_0000 | (32'd7 << 7) | 32'h40, 32'hA000_0000, 8'h11);
    write_ent(4, 32'h2000_0000 | (32'd5 << 7) | 32'h40, 32'hB000_0000, 8'h11);
    look(1'b1, 32'h2000_0123, 8'h11);
    look(1'b1, 32'h2080_0123, 8'h11);
    write_ent(4, 32'h2000_0000, 32'hB000_0000, 8'h11);
    look(1'b0, 32'h2000_0123, 8'h11);

    cur_req = "R5";
    xlate_d_en = 0;
    look(1'b1, 32'hDEAD_BEEF, 8'h11);
    look(1'b0, 32'hDEAD_BEEF, 8'h11);
    xlate_d_en = 1; xlate_i_en = 0;
    look(1'b0, 32'h5555_AAAA, 8'h00);
    look(1'b1, 32'h5555_AAAA, 8'h00);
    xlate_i_en = 1;

    cur_req = "R8";
    read_ent(9);
    read_ent(11);
    wr_en = 1; wr_idx = 6'd30; wr_hi = 32'h3000_0000 | (32'd7 << 7) | 32'h40;
    wr_lo = 32'hC000_0000; wr_tid = 8'h11;
    lk_valid = 1; lk_side = 1; lk_addr = 32'h3000_0040; lk_pid = 8'h11;
    rd_en = 1; rd_idx = 6'd9;
    tick(); idle_inputs();
    look(1'b1, 32'h3000_0040, 8'h11);
    wr_en = 1; wr_idx = 6'd30; wr_hi = 32'h3100_0000; wr_lo = 32'hD000_0000; wr_tid = 8'h22;
    rd_en = 1; rd_idx = 6'd30;
    tick(); idle_inputs();
    read_ent(30);

    cur_req = "R9";
    tick(); tick();
    look(1'b0, 32'h0100_0004, 8'h11);
    tick();

    cur_req = "R1";
    rst = 1; tick(); rst = 0;
    look(1'b1, 32'h0100_0004, 8'h11);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule